// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor countdown timer of a local interrupt controller. Software programs three things through a simple write port: a timer entry (interrupt vector, mask bit, periodic/one-shot mode bit), a divide code, and an initial count. A write of the initial count starts a new count. From that moment the block counts bus-clock cycles, scales them down by a power-of-two divider, and turns them into divided ticks.

When the programmed number of ticks has elapsed, the block raises a one-cycle interrupt request that carries the programmed vector. In one-shot mode this happens once. In periodic mode it repeats every period. The remaining count can be read at any time on a dedicated output.

A downstream interrupt acceptance stage consumes the pulse. Software reads the remaining count to measure time.

Top module: `local_tick_timer`

## Requirements
- R1: After reset the timer entry is masked, the vector is 0, the mode is one-shot, the divide code is 0 (divide by 2), the initial count is 0, `cur_count` reads 0, and `irq_pulse` is low.
- R2: The divide code is formed from write-data bits {3,1:0}, and bit 2 is ignored. Code 3'b111 divides by 1. Any other code n divides by 2^(n+1).
- R3: A write with `wr_sel`=2 (initial count) restarts counting from zero. `cur_count` equals the written value in the cycle after the write, and this holds even while the timer is masked.
- R4: In one-shot mode with a nonzero count C and divider D, `irq_pulse` is high in the cycle following the (C+1)·D-th clock edge after the loading edge. It does not pulse again until the count is rewritten.
- R5: In one-shot mode a count of zero never raises an interrupt.
- R6: In periodic mode with a nonzero count C, an interrupt pulse occurs every (C+1)·D cycles, measured from the loading edge.
- R7: In periodic mode a count of zero never raises an interrupt.
- R8: While the mask bit (entry bit 16, written with `wr_sel`=0) is set, no interrupt is raised, but counting still proceeds.
- R9: Each interrupt pulse lasts exactly one cycle. `irq_vector` carries entry bits [7:0] during the pulse and reads 0 otherwise. Entry bit 17 set selects periodic mode.
- R10: In one-shot mode `cur_count` reads C minus elapsed ticks, saturating at 0. In periodic mode it reads C minus the ticks elapsed in the current period.
- R11: A divide-code write (`wr_sel`=1) during a count does not restart the count. The new divider applies only to ticks after the write, and ticks already counted are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 entry, 1 divide code, 2 initial count, 3 none |
| wr_data | input | DATA_W | Write data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |
| cur_count | output | CNT_W | Remaining count readback |

## Verification
Expiry is exercised with four divide codes, including one with the ignored bit set and one that divides by one. The first-pulse cycle therefore separates shift decoding errors from off-by-one errors in the period. One-shot and periodic runs with small counts distinguish single from repeated firing. They also show the wrap point, through the second pulse position and the readback just after a wrap. Zero counts and masked runs show that suppression does not stop counting. A reload mid-count and a divide change mid-count tell a true restart apart from a retained elapsed count.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
    localparam int VEC_W     = 8;
    localparam int MASK_BIT  = 16;
    localparam int PER_BIT   = 17;
    localparam int MAX_SHIFT = 7;
    localparam int PRE_W     = MAX_SHIFT;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } wsel_e;

    // Divide code bits {3,1:0}: 3'b111 -> shift 0, otherwise n -> shift n+1
    function automatic logic [2:0] div_to_shift(input logic [3:0] code);
        logic [2:0] n;
        n = {code[3], code[1:0]};
        return (n == 3'b111) ? 3'd0 : n + 3'd1;
    endfunction
endpackage

// File: rtl/ltt_regs.sv
module ltt_regs
    import ltt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VEC_W-1:0]  vec,
    output logic              masked,
    output logic              periodic,
    output logic [2:0]        shift,
    output logic [CNT_W-1:0]  init_cnt,
    output logic              load
);
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             mask;
        logic             per;
        logic [2:0]       shift;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wdata;

    assign unused_wdata = ^wr_data;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                SEL_ENTRY: begin
                    r_d.vec  = wr_data[VEC_W-1:0];
                    r_d.mask = wr_data[MASK_BIT];
                    r_d.per  = wr_data[PER_BIT];
                end
                SEL_DIV:   r_d.shift = div_to_shift(wr_data[3:0]);
                SEL_COUNT: begin
                    r_d.cnt = wr_data[CNT_W-1:0];
                    load    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.mask  <= 1'b1;
            r_q.shift <= div_to_shift(4'd0);
        end else begin
            r_q <= r_d;
        end
    end

    assign vec      = r_q.vec;
    assign masked   = r_q.mask;
    assign periodic = r_q.per;
    assign shift    = r_q.shift;
    assign init_cnt = r_q.cnt;
endmodule

// File: rtl/ltt_prescaler.sv
module ltt_prescaler
    import ltt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [2:0] shift,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] low_mask;

    always_comb begin
        low_mask = PRE_W'((32'd1 << shift) - 32'd1);
        tick     = (pre_q & low_mask) == low_mask;
        pre_d    = clear ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/ltt_counter.sv
module ltt_counter
    import ltt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             masked,
    input  logic             periodic,
    input  logic [VEC_W-1:0] vec,
    input  logic [CNT_W-1:0] init_cnt,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec,
    output logic [CNT_W-1:0] cur
);
    localparam int RUN_W = CNT_W + 1;

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             irq;
        logic [VEC_W-1:0] ivec;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [RUN_W-1:0] cnt_ext;
    logic             hit;
    logic             fire;

    always_comb begin
        cnt_ext = {1'b0, init_cnt};
        hit     = tick && (s_q.run == cnt_ext) && (init_cnt != '0);
        fire    = hit && !masked && !clear;
        s_d     = s_q;
        if (clear) begin
            s_d.run = '0;
        end else if (tick) begin
            if (periodic)
                s_d.run = (s_q.run >= cnt_ext) ? '0 : s_q.run + 1'b1;
            else if (s_q.run <= cnt_ext)
                s_d.run = s_q.run + 1'b1;
        end
        s_d.irq  = fire;
        s_d.ivec = fire ? vec : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq     = s_q.irq;
    assign irq_vec = s_q.ivec;
    assign cur     = (s_q.run >= cnt_ext) ? '0 : init_cnt - s_q.run[CNT_W-1:0];
endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer
    import ltt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_pulse,
    output logic [7:0]        irq_vector,
    output logic [CNT_W-1:0]  cur_count
);
    logic [VEC_W-1:0] ent_vec;
    logic             ent_mask;
    logic             ent_per;
    logic [2:0]       div_shift;
    logic [CNT_W-1:0] init_cnt;
    logic             load;
    logic             tick;

    ltt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .vec(ent_vec), .masked(ent_mask),
        .periodic(ent_per), .shift(div_shift), .init_cnt(init_cnt),
        .load(load)
    );

    ltt_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clear(load), .shift(div_shift),
        .tick(tick)
    );

    ltt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(load), .tick(tick),
        .masked(ent_mask), .periodic(ent_per), .vec(ent_vec),
        .init_cnt(init_cnt), .irq(irq_pulse), .irq_vec(irq_vector),
        .cur(cur_count)
    );
endmodule

// File: rtl/ltt_checker.sv
module ltt_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_pulse,
    input logic [7:0]        irq_vector,
    input logic [CNT_W-1:0]  cur_count,
    input logic              masked,
    input logic              periodic,
    input logic [CNT_W-1:0]  init_cnt
);
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        masked |=> !irq_pulse);

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r9_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pulse |-> irq_vector == 8'd0);

    a_r7_zero_periodic: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic && init_cnt == '0) |=> !irq_pulse);

    a_r5_zero_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && init_cnt == '0) |=> !irq_pulse);

    a_r3_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> cur_count == $past(wr_data[CNT_W-1:0]));

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cur_count <= init_cnt);
endmodule

bind local_tick_timer ltt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector),
    .cur_count(cur_count), .masked(ent_mask), .periodic(ent_per),
    .init_cnt(init_cnt)
);

// File: tb/local_tick_timer_tb.sv
module local_tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        irq_pulse;
    logic [7:0]  irq_vector;
    logic [31:0] cur_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    local_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector),
        .cur_count(cur_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    function automatic logic [31:0] entry(input logic [7:0] v, input bit m, input bit p);
        return {14'd0, p, m, 8'd0, v};
    endfunction

    task automatic watch(input int n, input logic [7:0] v, input int probe_k,
                         output int first, output int second, output int cnt,
                         output int bad, output logic [31:0] probe_v);
        first = -1; second = -1; cnt = 0; bad = 0; probe_v = '0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq_pulse) begin
                cnt++;
                if (first < 0) first = k;
                else if (second < 0) second = k;
                if (irq_vector != v) bad++;
            end else if (irq_vector != 8'd0) begin
                bad++;
            end
            if (k == probe_k) probe_v = cur_count;
        end
    endtask

    task automatic t_reset();
        check(irq_pulse == 1'b0, "R1", "irq after reset", irq_pulse, 0);
        check(irq_vector == 8'd0, "R1", "vector after reset", irq_vector, 0);
        check(cur_count == 32'd0, "R1", "count after reset", cur_count, 0);
    endtask

    task automatic t_default_div();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd0, entry(8'h33, 1'b0, 1'b0));
        wr(2'd2, 32'd2);
        watch(10, 8'h33, 0, f, s, c, b, pv);
        check(f == 6, "R1", "reset divide by 2 first pulse", f, 6);
        check(c == 1 && b == 0, "R9", "pulse count/vector", c, 1);
    endtask

    task automatic t_div_codes();
        logic [3:0] codes [4] = '{4'b1011, 4'b0010, 4'b1000, 4'b0111};
        int exp_k [4] = '{2, 16, 64, 32};
        int f, s, c, b; logic [31:0] pv;
        for (int i = 0; i < 4; i++) begin
            wr(2'd2, 32'd0);
            wr(2'd1, {28'd0, codes[i]});
            wr(2'd0, entry(8'h5A, 1'b0, 1'b0));
            wr(2'd2, 32'd1);
            watch(70, 8'h5A, 0, f, s, c, b, pv);
            check(f == exp_k[i], "R2", "divide code first pulse", f, exp_k[i]);
        end
    endtask

    task automatic t_oneshot();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd2, 32'd0);
        wr(2'd1, 32'hB);
        wr(2'd0, entry(8'h41, 1'b0, 1'b0));
        wr(2'd2, 32'd4);
        watch(40, 8'h41, 2, f, s, c, b, pv);
        check(f == 5, "R4", "one-shot first pulse", f, 5);
        check(c == 1, "R4", "one-shot pulse count", c, 1);
        check(b == 0, "R9", "one-shot vector", b, 0);
        check(pv == 32'd2, "R10", "one-shot readback mid", pv, 2);
        check(cur_count == 32'd0, "R10", "one-shot readback after", cur_count, 0);
    endtask

    task automatic t_oneshot_zero();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd2, 32'd0);
        watch(30, 8'h41, 0, f, s, c, b, pv);
        check(c == 0, "R5", "one-shot zero pulses", c, 0);
    endtask

    task automatic t_periodic();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd2, 32'd0);
        wr(2'd0, entry(8'h77, 1'b0, 1'b1));
        wr(2'd2, 32'd3);
        watch(20, 8'h77, 5, f, s, c, b, pv);
        check(f == 4 && s == 8, "R6", "periodic pulse positions", s, 8);
        check(c == 5, "R6", "periodic pulse count", c, 5);
        check(b == 0, "R9", "periodic vector", b, 0);
        check(pv == 32'd2, "R10", "periodic readback after wrap", pv, 2);
    endtask

    task automatic t_periodic_zero();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd2, 32'd0);
        watch(30, 8'h77, 0, f, s, c, b, pv);
        check(c == 0, "R7", "periodic zero pulses", c, 0);
        check(cur_count == 32'd0, "R7", "periodic zero readback", cur_count, 0);
    endtask

    task automatic t_mask();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd2, 32'd0);
        wr(2'd0, entry(8'h12, 1'b1, 1'b0));
        wr(2'd2, 32'd3);
        check(cur_count == 32'd3, "R3", "load while masked", cur_count, 3);
        watch(10, 8'h12, 2, f, s, c, b, pv);
        check(c == 0, "R8", "masked pulses", c, 0);
        check(pv == 32'd1, "R8", "masked still counts", pv, 1);
    endtask

    task automatic t_reload();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd2, 32'd0);
        wr(2'd0, entry(8'h21, 1'b0, 1'b0));
        wr(2'd2, 32'd10);
        watch(5, 8'h21, 0, f, s, c, b, pv);
        wr(2'd2, 32'd3);
        check(cur_count == 32'd3, "R3", "reload readback", cur_count, 3);
        watch(20, 8'h21, 0, f, s, c, b, pv);
        check(f == 4 && c == 1, "R3", "reload restarts expiry", f, 4);
    endtask

    task automatic t_div_change();
        int f, s, c, b; logic [31:0] pv;
        wr(2'd2, 32'd0);
        wr(2'd1, 32'hB);
        wr(2'd0, entry(8'h66, 1'b1, 1'b0));
        wr(2'd2, 32'd20);
        watch(5, 8'h66, 5, f, s, c, b, pv);
        check(pv == 32'd15, "R11", "before divide change", pv, 15);
        wr(2'd1, 32'h0);
        check(cur_count == 32'd14, "R11", "no restart on divide write", cur_count, 14);
        watch(2, 8'h66, 2, f, s, c, b, pv);
        check(pv == 32'd13, "R11", "new divider after write", pv, 13);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_div();
        t_div_codes();
        t_oneshot();
        t_oneshot_zero();
        t_periodic();
        t_periodic_zero();
        t_mask();
        t_reload();
        t_div_change();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule